// File: doc/BRIEF.md
# USB Host Frame Timer

This block keeps frame timing for a full-speed USB host port. Software programs a 14-bit frame period. A 14-bit down counter loads from it and steps down once on each bit-time tick while counting is enabled. When a tick arrives with the counter at zero, the counter reloads from the period and the block raises a single-cycle start-of-frame request. The packet transmitter receives that request.

When the transmitter reports that a start-of-frame packet has gone out, an 11-bit frame number advances. The frame number always names the next frame to be sent. Software can read the live count to see how much of the current frame is left. Any write to the period register restarts the frame count at zero and starts a fresh frame at once.

Access goes through a small register port with a 2-bit address. Writes are single-cycle strobes. Reads are combinational.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset: enable is 0, period and count both equal RESET_PERIOD (default 11999), frame number is 0, and sof_req is low.
- R2: The read map is as follows. Address 0 returns the enable in bit 0. Address 1 returns the period in bits 13:0. Address 2 returns the live count in bits 13:0. Address 3 returns the frame number in bits 10:0. All other bits read as 0, including bits 15:14 after a write of all ones.
- R3: While enable is 1, each bt_tick pulse with a nonzero count lowers the count by exactly one.
- R4: While enable is 0, bt_tick pulses leave the count unchanged.
- R5: A tick that arrives with count 0 and enable 1 reloads the count from the period. In the following cycle, sof_req is high for exactly one cycle, so a frame lasts period+1 ticks.
- R6: A write to address 1 loads both the period and the live count from wdata[13:0] on the same clock edge.
- R7: A write to address 1 clears the frame number to 0. The clear takes priority over a simultaneous sof_done.
- R8: Each cycle in which sof_done is high raises the frame number by one. A sof_req on its own leaves the frame number unchanged.
- R9: The frame number wraps from 2047 to 0.
- R10: Writes to addresses 2 and 3 have no effect on the count or on the frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bt_tick | input | 1 | One-cycle bit-time pulse |
| sof_done | input | 1 | Pulse from the transmitter when a start-of-frame packet has been sent |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| sof_req | output | 1 | One-cycle start-of-frame request |

## Verification
Ticks are applied with counting disabled and then enabled. This separates a counter that really holds from one that ignores the enable bit. Short periods are run to expiry and across two consecutive frames. These runs measure reload and request timing, and they expose an off-by-one in frame length. The frame number is driven in four ways: by sof_done alone, by expiries without sof_done, by a period write that coincides with sof_done, and by a long burst through 2047. These patterns isolate the increment source, the clear priority and the wrap.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int CNT_W        = 14,
  parameter int FRM_W        = 11,
  parameter int DATA_W       = 16,
  parameter int RESET_PERIOD = 11999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bt_tick,
  input  logic              sof_done,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sof_req
);

  localparam logic [1:0] A_CTRL = 2'd0, A_PERIOD = 2'd1, A_COUNT = 2'd2, A_FRAME = 2'd3;

  logic             enable;
  logic [CNT_W-1:0] period, count;
  logic [FRM_W-1:0] frame;

  wire period_wr = wr_en && addr == A_PERIOD;
  wire step      = bt_tick && enable && !period_wr;
  wire expire    = step && count == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) enable <= 1'b0;
    else if (wr_en && addr == A_CTRL) enable <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      period <= CNT_W'(RESET_PERIOD);
      count  <= CNT_W'(RESET_PERIOD);
    end else if (period_wr) begin
      period <= wdata[CNT_W-1:0];
      count  <= wdata[CNT_W-1:0];
    end else if (expire) count <= period;
    else if (step)       count <= count - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sof_req <= 1'b0;
    else        sof_req <= expire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         frame <= '0;
    else if (period_wr) frame <= '0;
    else if (sof_done)  frame <= frame + 1'b1;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[0]       = enable;
      A_PERIOD: rdata[CNT_W-1:0] = period;
      A_COUNT:  rdata[CNT_W-1:0] = count;
      A_FRAME:  rdata[FRM_W-1:0] = frame;
      default:  rdata = '0;
    endcase
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CNT_W] == '0);

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !period_wr) |=> $stable(count));

  assert_sof_reloads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req |-> count == period);

  assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> count == $past(wdata[CNT_W-1:0]));

  assert_frame_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> frame == '0);

  assert_frame_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_done && !period_wr) |=> frame == $past(frame) + 1'b1);

  assert_frame_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_done && !period_wr) |=> $stable(frame));

endmodule

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  logic clk = 0, rst_n = 0, bt_tick = 0, sof_done = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic sof_req;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (.clk, .rst_n, .bt_tick, .sof_done, .wr_en,
    .addr, .wdata, .rdata, .sof_req);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick(output logic s);
    @(negedge clk); bt_tick = 1;
    @(negedge clk); bt_tick = 0; s = sof_req;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(0, d); check("R1 enable", d, 0);
    rd(1, d); check("R1 period", d, 11999);
    rd(2, d); check("R1 count", d, 11999);
    rd(3, d); check("R1 frame", d, 0);
    check("R1 sof_req", sof_req, 0);
  endtask

  task automatic t_hold;
    logic [15:0] d; logic s;
    wr(1, 16'd9);
    rd(2, d); check("R6 count load", d, 9);
    rd(1, d); check("R6 period load", d, 9);
    for (int i = 0; i < 5; i++) tick(s);
    rd(2, d); check("R4 hold", d, 9);
  endtask

  task automatic t_count;
    logic [15:0] d; logic s; int gap;
    wr(1, 16'd5); wr(0, 16'd1);
    rd(0, d); check("R2 enable bit", d, 1);
    for (int i = 0; i < 3; i++) tick(s);
    rd(2, d); check("R3 decrement", d, 2);
    tick(s); tick(s);
    rd(2, d); check("R3 reach zero", d, 0);
    check("R5 no early sof", s, 0);
    tick(s);
    check("R5 sof on expiry", s, 1);
    rd(2, d); check("R5 reload", d, 5);
    @(negedge clk); check("R5 one cycle", sof_req, 0);
    wr(1, 16'd3); gap = 0;
    do begin tick(s); gap++; end while (!s && gap < 20);
    check("R5 frame length", gap, 4);
    gap = 0;
    do begin tick(s); gap++; end while (!s && gap < 20);
    check("R5 second frame", gap, 4);
  endtask

  task automatic t_frame;
    logic [15:0] d; logic s;
    @(negedge clk); sof_done = 1; @(negedge clk); sof_done = 0;
    rd(3, d); check("R8 increment", d, 1);
    for (int i = 0; i < 8; i++) tick(s);
    rd(3, d); check("R8 sof_req alone", d, 1);
    wr(1, 16'd20);
    rd(3, d); check("R7 clear", d, 0);
    @(negedge clk); sof_done = 1; @(negedge clk); sof_done = 0;
    @(negedge clk); sof_done = 1; wr_en = 1; addr = 1; wdata = 16'd20;
    @(negedge clk); sof_done = 0; wr_en = 0;
    rd(3, d); check("R7 clear beats sof_done", d, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] d;
    @(negedge clk); sof_done = 1;
    repeat (2047) @(negedge clk);
    sof_done = 0;
    rd(3, d); check("R9 at max", d, 2047);
    @(negedge clk); sof_done = 1; @(negedge clk); sof_done = 0;
    rd(3, d); check("R9 wrap", d, 0);
  endtask

  task automatic t_ro;
    logic [15:0] d;
    wr(0, 16'd0);
    wr(1, 16'hFFFF);
    rd(1, d); check("R2 reserved period", d, 16'h3FFF);
    rd(2, d); check("R2 reserved count", d, 16'h3FFF);
    @(negedge clk); sof_done = 1; @(negedge clk); sof_done = 0;
    wr(2, 16'h0123); wr(3, 16'h0456);
    rd(2, d); check("R10 count untouched", d, 16'h3FFF);
    rd(3, d); check("R10 frame untouched", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_count();
    t_frame();
    t_wrap();
    t_ro();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule